// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Boundary-Aligned Reconfiguration

This block produces four independent pulse-width modulated outputs from one input clock. Software reaches it through a flat register window: each channel owns a 32-byte bank. A bank holds a clock divider, a step count per period, a high-time count and a run bit. A channel divides the clock by its divider setting and counts the divided ticks to build a period. Its output is high for the first part of each period and low for the rest.

Divider and step-count writes only stage new values. The write of the high-time count turns the staged trio into a pending configuration. The running channel switches to the pending configuration at the end of the period in progress, so one period never mixes two settings. Clearing the run bit does not wait for the period to end: the output drops on the next cycle. A channel started from idle begins a fresh period using the newest committed settings.

Access is single-cycle. A write lands on the clock edge where the write enable is high. The read data is a combinational function of the address.

Top module: `mpwm_ctrl`

## Requirements
- R1: The bank of channel c starts at byte address c*32, that is, address bits [6:5] select the channel. Inside a bank the offsets are 0x00 divider (bits [7:0]), 0x04 step count (bits [7:0]), 0x08 high-time count (bits [15:0]) and 0x18 run bit (bit 0).
- R2: Reading a mapped offset returns, in the same cycle, the last value written to that field, and all bits outside the field read as zero.
- R3: Any other offset reads as zero, and a write to it changes no register and no output.
- R4: With divider P, step count M >= 1 and high-time count D < M committed and the channel running, every period lasts (P+1)*M cycles. The output is high for the first (P+1)*D cycles of each period.
- R5: Writes to the divider or step count that are not followed by a high-time write leave the output waveform unchanged.
- R6: A high-time write commits the staged divider, the staged step count and the written high-time count together. On a running channel the current period finishes with the old settings, and the new settings apply from the next period.
- R7: Writing 0 to the run bit drives that channel's output low from the cycle after the write edge, even in mid-period.
- R8: Writing 1 to the run bit of an idle channel starts a period in the cycle after the write edge, with counters at zero and the most recently committed settings. These settings include a commit made while the channel was idle.
- R9: When D >= M the output stays high for the whole period. When M = 0 the output stays low while the channel runs.
- R10: Each channel's registers and output are unaffected by accesses to the other banks.
- R11: After reset all registers read zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registers and counters |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 7 | Byte address of the register access |
| reg_we | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pwm_out | output | 4 | One waveform output per channel |

## Verification
The assertions check on every cycle that field bits beyond each register's width read zero and that unmapped offsets read zero. They also check that a write reads back on the next cycle, and that a run-bit clear forces the output low on the next cycle. Waveform shapes depend on counters and on when a commit lands within a period, so only the bench scenarios can show them. These shapes include period and high-time lengths, the deferral of a committed change to the period boundary, the lack of effect of staged writes, and the restart from idle. The bench predicts each output sample from the settings it wrote and compares the predictions cycle by cycle.

// File: rtl/mpwm_pkg.sv
// Package: shared field widths, register offsets and the channel setting type.
// Assumes byte addressing with 32-byte banks per channel.
package mpwm_pkg;
    localparam int BANK_SHIFT = 5;
    localparam int PSC_W      = 8;
    localparam int MOD_W      = 8;
    localparam int DUTY_W     = 16;
    localparam int DATA_W     = 32;

    localparam logic [BANK_SHIFT-1:0] OFF_DIV  = 5'h00;
    localparam logic [BANK_SHIFT-1:0] OFF_STEP = 5'h04;
    localparam logic [BANK_SHIFT-1:0] OFF_HIGH = 5'h08;
    localparam logic [BANK_SHIFT-1:0] OFF_RUN  = 5'h18;

    typedef struct packed {
        logic [PSC_W-1:0]  div;
        logic [MOD_W-1:0]  steps;
        logic [DUTY_W-1:0] high;
    } pwm_cfg_t;
endpackage

// File: rtl/mpwm_regs.sv
// Module: register banks for all channels. It stages divider and step-count
// writes, keeps the run bits, and raises a one-cycle commit strobe together
// with the full new setting when a high-time count is written.
// Assumes a single-cycle access and a combinational read path.
module mpwm_regs
    import mpwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = BANK_SHIFT + $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] run,
    output logic [NUM_CH-1:0] commit,
    output pwm_cfg_t          commit_cfg
);
    localparam int CH_W = ADDR_W - BANK_SHIFT;

    logic [CH_W-1:0]       ch_sel;
    logic [BANK_SHIFT-1:0] off;
    logic                  ch_ok;
    logic [PSC_W-1:0]      div_q  [NUM_CH];
    logic [MOD_W-1:0]      step_q [NUM_CH];
    logic [DUTY_W-1:0]     high_q [NUM_CH];
    logic [NUM_CH-1:0]     run_q;

    // Split the address into channel index and in-bank offset.
    always_comb begin
        ch_sel = addr[ADDR_W-1:BANK_SHIFT];
        off    = addr[BANK_SHIFT-1:0];
        ch_ok  = (32'(ch_sel) < NUM_CH);
    end

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_bank
            logic hit;
            // Decode whether this access targets this channel's bank.
            always_comb hit = we && ch_ok && (32'(ch_sel) == g);

            // Hold this channel's fields; unmapped offsets fall through.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    div_q[g]  <= '0;
                    step_q[g] <= '0;
                    high_q[g] <= '0;
                    run_q[g]  <= 1'b0;
                end else if (hit) begin
                    case (off)
                        OFF_DIV:  div_q[g]  <= wdata[PSC_W-1:0];
                        OFF_STEP: step_q[g] <= wdata[MOD_W-1:0];
                        OFF_HIGH: high_q[g] <= wdata[DUTY_W-1:0];
                        OFF_RUN:  run_q[g]  <= wdata[0];
                        default: ;
                    endcase
                end
            end

            // One-cycle commit strobe on a high-time write.
            always_comb commit[g] = hit && (off == OFF_HIGH);
        end
    endgenerate

    // The committed setting uses the staged fields plus the new high time.
    always_comb begin
        commit_cfg = '0;
        if (ch_ok) begin
            commit_cfg.div   = div_q[ch_sel];
            commit_cfg.steps = step_q[ch_sel];
        end
        commit_cfg.high = wdata[DUTY_W-1:0];
    end

    // Read mux, zero for unmapped offsets and beyond field widths.
    always_comb begin
        rdata = '0;
        if (ch_ok) begin
            case (off)
                OFF_DIV:  rdata = DATA_W'(div_q[ch_sel]);
                OFF_STEP: rdata = DATA_W'(step_q[ch_sel]);
                OFF_HIGH: rdata = DATA_W'(high_q[ch_sel]);
                OFF_RUN:  rdata = DATA_W'(run_q[ch_sel]);
                default:  rdata = '0;
            endcase
        end
    end

    assign run = run_q;
endmodule

// File: rtl/mpwm_chan.sv
// Module: one waveform channel. It keeps a pending and an active setting,
// swaps at a period boundary (or at once while idle), runs a divider counter
// and a step counter, and drives the output high while step < high count.
// Assumes commit is a one-cycle strobe from the register block.
module mpwm_chan
    import mpwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  logic     commit,
    input  pwm_cfg_t commit_cfg,
    output logic     pwm
);
    pwm_cfg_t          pend_q;
    logic              pend_vld;
    pwm_cfg_t          act_q;
    logic [PSC_W-1:0]  div_cnt;
    logic [MOD_W-1:0]  step_cnt;
    logic              tick_end;
    logic              period_end;
    logic              swap_ok;

    // Detect the last cycle of a divided tick and of a whole period.
    always_comb begin
        tick_end   = (div_cnt == act_q.div);
        period_end = tick_end &&
                     ((act_q.steps == '0) || (step_cnt == act_q.steps - 1'b1));
        swap_ok    = !run || period_end;
    end

    // Pending setting: a new commit replaces it, a swap consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= '0;
            pend_vld <= 1'b0;
        end else if (commit && !swap_ok) begin
            pend_q   <= commit_cfg;
            pend_vld <= 1'b1;
        end else if (swap_ok) begin
            pend_vld <= 1'b0;
        end
    end

    // Active setting: loaded only when a period ends or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (swap_ok && commit) begin
            act_q <= commit_cfg;
        end else if (swap_ok && pend_vld) begin
            act_q <= pend_q;
        end
    end

    // Divider and step counters; held at zero while the channel is idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_cnt  <= '0;
            step_cnt <= '0;
        end else if (tick_end) begin
            div_cnt  <= '0;
            step_cnt <= period_end ? '0 : step_cnt + 1'b1;
        end else begin
            div_cnt  <= div_cnt + 1'b1;
        end
    end

    // High during the first part of the period; low when idle or empty.
    always_comb pwm = run && (act_q.steps != '0) &&
                      (DUTY_W'(step_cnt) < act_q.high);
endmodule

// File: rtl/mpwm_ctrl.sv
// Module: top of the multi-channel modulator. It joins the register banks to
// one channel instance per output.
// Assumes one clock domain and a synchronous active-low reset.
module mpwm_ctrl
    import mpwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int ADDR_W = BANK_SHIFT + $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [NUM_CH-1:0] run;
    logic [NUM_CH-1:0] commit;
    pwm_cfg_t          commit_cfg;

    mpwm_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (reg_addr),
        .we         (reg_we),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .run        (run),
        .commit     (commit),
        .commit_cfg (commit_cfg)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_chan
            mpwm_chan u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .run        (run[g]),
                .commit     (commit[g]),
                .commit_cfg (commit_cfg),
                .pwm        (pwm_out[g])
            );
        end
    endgenerate
endmodule

// File: rtl/mpwm_ctrl_chk.sv
// Module: port-level property checker for the modulator, bound to the top.
// Assumes the register offsets from the shared package.
module mpwm_ctrl_chk
    import mpwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = BANK_SHIFT + $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [NUM_CH-1:0] pwm_out
);
    logic [BANK_SHIFT-1:0] off;
    logic                  mapped;
    logic [DATA_W-1:0]     fmask;

    // Classify the current offset and its field mask.
    always_comb begin
        off = reg_addr[BANK_SHIFT-1:0];
        case (off)
            OFF_DIV:  begin mapped = 1'b1; fmask = DATA_W'({PSC_W{1'b1}});  end
            OFF_STEP: begin mapped = 1'b1; fmask = DATA_W'({MOD_W{1'b1}});  end
            OFF_HIGH: begin mapped = 1'b1; fmask = DATA_W'({DUTY_W{1'b1}}); end
            OFF_RUN:  begin mapped = 1'b1; fmask = DATA_W'(1);              end
            default:  begin mapped = 1'b0; fmask = '0;                      end
        endcase
    end

    // R3: unmapped offsets read zero.
    assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> reg_rdata == '0);

    // R2: bits outside a field read zero.
    assert_field_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mapped |-> (reg_rdata & ~fmask) == '0);

    // R2: a mapped write reads back next cycle at the same address.
    assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && mapped) |=>
        ((reg_addr != $past(reg_addr)) || (reg_rdata == ($past(reg_wdata) & fmask))));

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_stop
            // R7: clearing the run bit drops the output on the next cycle.
            assert_stop_now_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_we && (32'(reg_addr[ADDR_W-1:BANK_SHIFT]) == g) &&
                 (off == OFF_RUN) && !reg_wdata[0]) |=> !pwm_out[g]);
        end
    endgenerate
endmodule

bind mpwm_ctrl mpwm_ctrl_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pwm_out   (pwm_out)
);

// File: tb/mpwm_ctrl_test.sv
// Bench: scoreboard of predicted output samples, popped once per cycle.
module mpwm_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  pwm_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    typedef struct {
        int    ch;
        bit    lvl;
        string tag;
    } item_t;
    item_t exp_q[$];

    mpwm_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
    );

    always #2.5 clk = ~clk;

    // Watchdog: an expired run counts as a failure and still summarises.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
            $finish;
        end
    end

    // Monitor: pop one predicted sample per cycle and compare.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            checks++;
            if (pwm_out[it.ch] !== it.lvl) begin
                fails++;
                $display("FAIL %s ch%0d actual=%b expected=%b", it.tag, it.ch,
                         pwm_out[it.ch], it.lvl);
            end
        end
    end

    task automatic wr(input int ch, input int off, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = 7'((ch << 5) + off);
        reg_we    = 1'b1;
        reg_wdata = d;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic rd(input int ch, input int off, input logic [31:0] e,
                      input string tag);
        @(negedge clk);
        reg_addr = 7'((ch << 5) + off);
        #1;
        checks++;
        if (reg_rdata !== e) begin
            fails++;
            $display("FAIL %s read ch%0d off%0h actual=%h expected=%h", tag, ch,
                     off, reg_rdata, e);
        end
    endtask

    task automatic chk(input bit cond, input string tag, input int act,
                       input int e);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, e);
        end
    endtask

    // Driver: predict whole periods from the requirement formulas.
    task automatic push_wave(input int ch, input int p, input int m,
                             input int d, input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            if (m == 0) begin
                for (int t = 0; t <= p; t++) exp_q.push_back('{ch, 1'b0, tag});
            end else begin
                for (int s = 0; s < m; s++)
                    for (int t = 0; t <= p; t++)
                        exp_q.push_back('{ch, bit'(s < d), tag});
            end
        end
    endtask

    task automatic push_lvl(input int ch, input bit v, input int n,
                            input string tag);
        for (int k = 0; k < n; k++) exp_q.push_back('{ch, v, tag});
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11: reset state.
        @(negedge clk);
        chk(pwm_out == 4'b0, "R11 outputs low", int'(pwm_out), 0);
        rd(2, 'h08, 32'h0, "R11");
        rd(3, 'h18, 32'h0, "R11");

        // R1 R2: map and field widths on channel 1.
        wr(1, 'h00, 32'h0000_01FF);
        wr(1, 'h04, 32'h0000_ABCD);
        wr(1, 'h08, 32'h0001_2345);
        wr(1, 'h18, 32'hFFFF_FFFE);
        rd(1, 'h00, 32'h0000_00FF, "R1 R2 divider");
        rd(1, 'h04, 32'h0000_00CD, "R1 R2 steps");
        rd(1, 'h08, 32'h0000_2345, "R1 R2 high");
        rd(1, 'h18, 32'h0, "R2 run");

        // R3: unmapped offsets.
        wr(1, 'h0C, 32'hFFFF_FFFF);
        wr(1, 'h1C, 32'hFFFF_FFFF);
        rd(1, 'h0C, 32'h0, "R3 read");
        rd(1, 'h1C, 32'h0, "R3 read");
        rd(1, 'h00, 32'h0000_00FF, "R3 no side effect");
        chk(pwm_out == 4'b0, "R3 outputs", int'(pwm_out), 0);

        // R4: P=2 M=3 D=2 gives 9-cycle periods, 6 high.
        wr(1, 'h00, 2);
        wr(1, 'h04, 3);
        wr(1, 'h08, 2);
        wr(1, 'h18, 1);
        push_wave(1, 2, 3, 2, 2, "R4");
        drain();
        wr(1, 'h18, 0);

        // R5: staged writes without a commit change nothing.
        wr(0, 'h00, 0);
        wr(0, 'h04, 4);
        wr(0, 'h08, 1);
        wr(0, 'h18, 1);
        push_wave(0, 0, 4, 1, 3, "R5");
        wr(0, 'h04, 2);
        wr(0, 'h00, 3);
        drain();
        rd(0, 'h04, 32'h2, "R2 staged");
        wr(0, 'h04, 4);
        wr(0, 'h00, 0);

        // R8 R6: restart from zero, then commit mid-period.
        wr(0, 'h18, 0);
        wr(0, 'h18, 1);
        push_wave(0, 0, 4, 1, 1, "R6 old period");
        push_wave(0, 0, 4, 3, 2, "R6 new period");
        wr(0, 'h08, 3);
        drain();

        // R9 R7: full-high, then immediate stop mid-period.
        wr(2, 'h00, 0);
        wr(2, 'h04, 4);
        wr(2, 'h08, 9);
        wr(2, 'h18, 1);
        push_lvl(2, 1'b1, 3, "R9 full high");
        push_lvl(2, 1'b0, 3, "R7 stop");
        repeat (2) @(negedge clk);
        wr(2, 'h18, 0);
        drain();

        // R9: zero steps holds the output low.
        wr(3, 'h00, 0);
        wr(3, 'h04, 0);
        wr(3, 'h08, 5);
        wr(3, 'h18, 1);
        push_lvl(3, 1'b0, 8, "R9 zero steps");
        drain();

        // R8: commit while idle is used at start.
        wr(2, 'h00, 1);
        wr(2, 'h04, 3);
        wr(2, 'h08, 1);
        wr(2, 'h18, 1);
        push_wave(2, 1, 3, 1, 2, "R8 idle commit");
        drain();

        // R10: other banks untouched.
        rd(0, 'h08, 32'h3, "R10 ch0 high");
        rd(0, 'h18, 32'h1, "R10 ch0 run");
        rd(1, 'h00, 32'h2, "R10 ch1 divider");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule